// File: doc/BRIEF.md
# Opcode-Snooping Packet Port

This block lets a CPU exchange command and result packets with a peripheral controller without any address decoding. The CPU asks for service by executing HALT. On the falling edge of the halt indication, the port raises an active-low interrupt request. During the interrupt acknowledge it places a restart opcode on the data bus as the mode-0 vector. The CPU's handler then runs a short copy loop. The port watches the opcodes being fetched. A "load A from (HL)" fetch tells it that the next memory read carries a command byte. A "store A to (DE)" fetch tells it that the next memory write is the slot in which it drives a result byte.

Captured command bytes collect in a command buffer. The first store opcode closes the command phase and raises a one-cycle command-ready strobe together with the byte count. Results come from a response FIFO that is loaded before they are requested. The transaction ends after the write slot that drains the FIFO. The port can also deliver results that were not requested: a notify pulse raises the interrupt with a second restart vector, which enters the handler's result-only loop directly. Only one transaction can be in progress at a time.

Top module: `snoop_io_port`

## Requirements
- R1: After reset `int_n` is high, `data_oe` is low, `cmd_valid` is low and `rsp_full` is low.
- R2: A high-to-low transition of `halt_n` while idle and `video_busy` is low makes `int_n` low from the following cycle.
- R3: A high-to-low transition of `halt_n` while `video_busy` is high is ignored: `int_n` stays high.
- R4: An acknowledge cycle (`m1_n` and `iorq_n` both low) while the interrupt is pending drives 0xCF on `data_out` with `data_oe` high for a halt request. `int_n` is high from the next cycle.
- R5: After an opcode fetch (`m1_n` and `rd_n` low) of 0x7E, the next memory read (`rd_n` low, `m1_n` high) is stored as the next command byte. Byte k sits in `cmd_bytes[8k+7:8k]`.
- R6: A memory read that does not follow a 0x7E fetch is not captured.
- R7: The first 0x12 fetch of a halt transaction closes the command phase. `cmd_valid` is high for exactly the one cycle after that fetch, with `cmd_count` equal to the number of captured bytes.
- R8: A memory write (`wr_n` low) that follows a 0x12 fetch has `data_oe` high and the FIFO head on `data_out`. Any other write cycle leaves `data_oe` low.
- R9: The write slot that leaves the response FIFO empty returns the port to idle. A slot met with an empty FIFO drives 0x00 and also ends the transaction.
- R10: A `halt_n` falling edge during an active transaction is ignored: `int_n` stays high.
- R11: A `notify` pulse while idle (with `video_busy` low) makes `int_n` low. The acknowledge vector is then 0xE7, the command phase is skipped, and `cmd_valid` does not pulse.
- R12: Command bytes beyond `CMD_DEPTH` are dropped, and `cmd_count` saturates at `CMD_DEPTH`.
- R13: `rsp_full` is high when `RSP_DEPTH` bytes are held. A push while the FIFO is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_n | input | 1 | CPU halt indication, active low |
| m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| rd_n | input | 1 | Memory read strobe, active low |
| wr_n | input | 1 | Memory write strobe, active low |
| iorq_n | input | 1 | I/O request, low with m1_n for acknowledge |
| data_in | input | 8 | Data bus as seen by the port |
| video_busy | input | 1 | Video engine owns the bus; halt requests refused |
| notify | input | 1 | Pulse to start an unsolicited result delivery |
| rsp_wr | input | 1 | Push strobe for the response FIFO |
| rsp_data | input | 8 | Byte pushed into the response FIFO |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| data_oe | output | 1 | Port drives the data bus |
| data_out | output | 8 | Vector or result byte driven onto the bus |
| cmd_valid | output | 1 | One-cycle command-ready strobe |
| cmd_count | output | 4 | Number of captured command bytes |
| cmd_bytes | output | 64 | Command buffer, byte 0 in the low bits |
| rsp_full | output | 1 | Response FIFO full |

## Verification
The command stream interleaves 0x7E fetches with fetches of unrelated opcodes, and includes a memory read that follows a different load opcode. Only reads armed by 0x7E may appear in the buffer, which separates opcode-armed capture from capturing every read. Write cycles are issued both after a 0x12 fetch and after other fetches, which separates opcode-armed driving from driving every write. Delivery is run with a two-entry FIFO, a full FIFO plus an extra push, and an empty FIFO. These show whether the end of the transaction follows the FIFO draining and whether the filler byte appears. Halt edges during video activity and during a live transaction, and a notify start, confirm that the two vectors and the refusal rules are kept apart.

// File: rtl/snoop_io_pkg.sv
package snoop_io_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_CMD,
        ST_RSP
    } xact_state_t;

    typedef struct packed {
        logic fetch;
        logic mem_rd;
        logic mem_wr;
        logic int_ack;
    } bus_cycle_t;

    localparam logic [7:0] OP_LOAD_A_HL  = 8'h7E;
    localparam logic [7:0] OP_STORE_A_DE = 8'h12;
    localparam logic [7:0] VEC_CMD_LOOP  = 8'hCF;
    localparam logic [7:0] VEC_RSP_LOOP  = 8'hE7;
    localparam logic [7:0] EMPTY_FILL    = 8'h00;

    function automatic bus_cycle_t classify_cycle(
        input logic m1_n, input logic rd_n, input logic wr_n, input logic iorq_n);
        bus_cycle_t c;
        c.fetch   = !m1_n && !rd_n && iorq_n;
        c.int_ack = !m1_n && !iorq_n;
        c.mem_rd  = m1_n && !rd_n && iorq_n;
        c.mem_wr  = m1_n && !wr_n && iorq_n;
        return c;
    endfunction

endpackage

// File: rtl/snoop_bus_decode.sv
module snoop_bus_decode
    import snoop_io_pkg::*;
(
    input  logic       m1_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       iorq_n,
    input  logic [7:0] data_in,
    output bus_cycle_t cyc,
    output logic       op_load,
    output logic       op_store
);
    always_comb begin
        cyc      = classify_cycle(m1_n, rd_n, wr_n, iorq_n);
        op_load  = cyc.fetch && (data_in == OP_LOAD_A_HL);
        op_store = cyc.fetch && (data_in == OP_STORE_A_DE);
    end
endmodule

// File: rtl/snoop_cmd_buf.sv
module snoop_cmd_buf #(
    parameter int CMD_DEPTH = 8,
    localparam int CW = $clog2(CMD_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clear,
    input  logic                   capture,
    input  logic                   close,
    input  logic [7:0]             byte_in,
    output logic                   cmd_valid,
    output logic [CW-1:0]          cmd_count,
    output logic [CMD_DEPTH*8-1:0] cmd_bytes
);
    logic [7:0] store_q [CMD_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_count <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= close;
            if (clear) begin
                cmd_count <= '0;
            end else if (capture && (cmd_count < CW'(CMD_DEPTH))) begin
                cmd_count <= cmd_count + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < CMD_DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!clear && capture && (cmd_count == CW'(g))) begin
                store_q[g] <= byte_in;
            end
        end
        assign cmd_bytes[g*8 +: 8] = store_q[g];
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_count_saturates_R12: assert property (@(posedge clk) disable iff (rst)
        (capture && !clear && cmd_count == CW'(CMD_DEPTH)) |=> cmd_count == CW'(CMD_DEPTH));

endmodule

// File: rtl/snoop_rsp_fifo.sv
module snoop_rsp_fifo #(
    parameter int RSP_DEPTH = 4,
    localparam int AW = (RSP_DEPTH > 1) ? $clog2(RSP_DEPTH) : 1,
    localparam int LW = $clog2(RSP_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          push_ok
);
    logic [7:0]    mem_q [RSP_DEPTH];
    logic [AW-1:0] wptr_q, rptr_q;
    logic          pop_ok;

    assign full    = (level == LW'(RSP_DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && (level != '0);
    assign head    = mem_q[rptr_q];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(RSP_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wptr_q] <= push_data;
                wptr_q        <= bump(wptr_q);
            end
            if (pop_ok) rptr_q <= bump(rptr_q);
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_no_overflow_R13: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/snoop_io_port.sv
module snoop_io_port
    import snoop_io_pkg::*;
#(
    parameter int CMD_DEPTH = 8,
    parameter int RSP_DEPTH = 4,
    localparam int CW = $clog2(CMD_DEPTH + 1),
    localparam int LW = $clog2(RSP_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   halt_n,
    input  logic                   m1_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic                   iorq_n,
    input  logic [7:0]             data_in,
    input  logic                   video_busy,
    input  logic                   notify,
    input  logic                   rsp_wr,
    input  logic [7:0]             rsp_data,
    output logic                   int_n,
    output logic                   data_oe,
    output logic [7:0]             data_out,
    output logic                   cmd_valid,
    output logic [CW-1:0]          cmd_count,
    output logic [CMD_DEPTH*8-1:0] cmd_bytes,
    output logic                   rsp_full
);
    xact_state_t   st_q;
    bus_cycle_t    cyc;
    logic          op_load, op_store;
    logic          halt_q, halt_fall;
    logic          rd_arm_q, wr_arm_q, unsol_q;
    logic          start_halt, start_note, ack_now;
    logic          capture, close, deliver, ending;
    logic [7:0]    rsp_head;
    logic [LW-1:0] rsp_level;
    logic          rsp_push_ok;

    snoop_bus_decode i_decode (
        .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n), .iorq_n(iorq_n),
        .data_in(data_in), .cyc(cyc), .op_load(op_load), .op_store(op_store)
    );

    assign halt_fall  = halt_q && !halt_n;
    assign start_halt = (st_q == ST_IDLE) && !video_busy && halt_fall;
    assign start_note = (st_q == ST_IDLE) && !video_busy && !halt_fall && notify;
    assign ack_now    = (st_q == ST_REQ) && cyc.int_ack;
    assign capture    = (st_q == ST_CMD) && cyc.mem_rd && rd_arm_q;
    assign close      = (st_q == ST_CMD) && op_store;
    assign deliver    = (st_q == ST_RSP) && cyc.mem_wr && wr_arm_q;
    assign ending     = deliver && ((rsp_level == '0) ||
                                    ((rsp_level == LW'(1)) && !rsp_push_ok));

    snoop_cmd_buf #(.CMD_DEPTH(CMD_DEPTH)) i_cmd (
        .clk(clk), .rst(rst), .clear(start_halt), .capture(capture),
        .close(close), .byte_in(data_in), .cmd_valid(cmd_valid),
        .cmd_count(cmd_count), .cmd_bytes(cmd_bytes)
    );

    snoop_rsp_fifo #(.RSP_DEPTH(RSP_DEPTH)) i_rsp (
        .clk(clk), .rst(rst), .push(rsp_wr), .push_data(rsp_data),
        .pop(deliver), .head(rsp_head), .level(rsp_level),
        .full(rsp_full), .push_ok(rsp_push_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q   <= 1'b1;
            st_q     <= ST_IDLE;
            rd_arm_q <= 1'b0;
            wr_arm_q <= 1'b0;
            unsol_q  <= 1'b0;
        end else begin
            halt_q <= halt_n;
            unique case (st_q)
                ST_IDLE: begin
                    if (start_halt) begin
                        st_q    <= ST_REQ;
                        unsol_q <= 1'b0;
                    end else if (start_note) begin
                        st_q    <= ST_REQ;
                        unsol_q <= 1'b1;
                    end
                end
                ST_REQ: begin
                    if (cyc.int_ack) begin
                        st_q     <= unsol_q ? ST_RSP : ST_CMD;
                        rd_arm_q <= 1'b0;
                        wr_arm_q <= 1'b0;
                    end
                end
                ST_CMD: begin
                    if (cyc.fetch) begin
                        rd_arm_q <= op_load;
                        if (op_store) begin
                            st_q     <= ST_RSP;
                            wr_arm_q <= 1'b1;
                        end
                    end else if (cyc.mem_rd) begin
                        rd_arm_q <= 1'b0;
                    end
                end
                ST_RSP: begin
                    if (cyc.fetch) begin
                        wr_arm_q <= op_store;
                    end else if (deliver) begin
                        wr_arm_q <= 1'b0;
                        if (ending) st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        int_n    = (st_q != ST_REQ);
        data_oe  = ack_now || deliver;
        data_out = 8'h00;
        if (ack_now)
            data_out = unsol_q ? VEC_RSP_LOOP : VEC_CMD_LOOP;
        else if (deliver)
            data_out = (rsp_level == '0) ? EMPTY_FILL : rsp_head;
    end

    assert_int_released_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_REQ) && cyc.int_ack) |=> int_n);

    assert_vector_driven_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_REQ) && cyc.int_ack) |-> (data_oe && (data_out[7:6] == 2'b11)));

    assert_busy_halt_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_IDLE) && video_busy) |=> int_n);

    assert_no_reentry_R10: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_CMD) || (st_q == ST_RSP)) |=> (st_q != ST_REQ));

    assert_no_stray_drive_R8: assert property (@(posedge clk) disable iff (rst)
        (cyc.mem_wr && (st_q != ST_RSP)) |-> !data_oe);

    assert_cmd_only_halt_R11: assert property (@(posedge clk) disable iff (rst)
        (unsol_q && (st_q == ST_RSP)) |=> !cmd_valid);

endmodule

// File: tb/test_snoop_io_port.sv
module test_snoop_io_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, iorq_n = 1'b1;
    logic [7:0]  din = 8'h00;
    logic        video_busy = 1'b0, notify = 1'b0, rsp_wr = 1'b0;
    logic [7:0]  rsp_data = 8'h00;
    logic        int_n, data_oe, cmd_valid, rsp_full;
    logic [7:0]  data_out;
    logic [3:0]  cmd_count;
    logic [63:0] cmd_bytes;

    logic        c_oe;
    logic [7:0]  c_dout;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snoop_io_port i_snoop_io_port (
        .clk(clk), .rst(rst), .halt_n(halt_n), .m1_n(m1_n), .rd_n(rd_n),
        .wr_n(wr_n), .iorq_n(iorq_n), .data_in(din), .video_busy(video_busy),
        .notify(notify), .rsp_wr(rsp_wr), .rsp_data(rsp_data), .int_n(int_n),
        .data_oe(data_oe), .data_out(data_out), .cmd_valid(cmd_valid),
        .cmd_count(cmd_count), .cmd_bytes(cmd_bytes), .rsp_full(rsp_full)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock: capture combinational outputs, take the edge, release strobes
    task automatic tick();
        #1;
        c_oe   = data_oe;
        c_dout = data_out;
        @(posedge clk);
        #1;
        m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; iorq_n = 1'b1;
        notify = 1'b0; rsp_wr = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] op); m1_n = 0; rd_n = 0; din = op; tick(); endtask
    task automatic mread(input logic [7:0] d);  rd_n = 0; din = d; tick(); endtask
    task automatic mwrite();                    wr_n = 0; tick(); endtask
    task automatic ack();                       m1_n = 0; iorq_n = 0; tick(); endtask
    task automatic push(input logic [7:0] d);   rsp_wr = 1; rsp_data = d; tick(); endtask
    task automatic halt_pulse();
        halt_n = 0; tick(); halt_n = 1;
    endtask

    task automatic t_reset();
        chk("R1 int_n", int_n, 1);
        chk("R1 data_oe", data_oe, 0);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 rsp_full", rsp_full, 0);
    endtask

    task automatic t_busy();
        video_busy = 1;
        halt_n = 0; tick();
        chk("R3 int_n", int_n, 1);
        halt_n = 1; tick();
        video_busy = 0; tick();
        chk("R3 int_n later", int_n, 1);
    endtask

    task automatic t_packet();
        push(8'hA1); push(8'hB2);
        chk("R13 not full", rsp_full, 0);
        halt_pulse();
        chk("R2 int_n", int_n, 0);
        ack();
        chk("R4 oe", c_oe, 1);
        chk("R4 vector", c_dout, 8'hCF);
        chk("R4 int_n released", int_n, 1);
        fetch(8'h7E); mread(8'h11);
        fetch(8'h23); fetch(8'h10);
        fetch(8'h3A); mread(8'h99);
        fetch(8'h7E); mread(8'h22);
        mwrite();
        chk("R8 unarmed write", c_oe, 0);
        halt_pulse(); tick();
        chk("R10 int_n", int_n, 1);
        fetch(8'h12);
        chk("R7 cmd_valid", cmd_valid, 1);
        chk("R7 cmd_count", cmd_count, 2);
        chk("R5 bytes", cmd_bytes[15:0], 16'h2211);
        chk("R6 stray read", cmd_bytes[23:16] == 8'h99 && cmd_count > 2, 0);
        mwrite();
        chk("R8 oe", c_oe, 1);
        chk("R8 head", c_dout, 8'hA1);
        chk("R7 pulse ends", cmd_valid, 0);
        fetch(8'h13); fetch(8'h10);
        mwrite();
        chk("R8 write after other fetch", c_oe, 0);
        fetch(8'h12); mwrite();
        chk("R8 second", c_dout, 8'hB2);
        halt_pulse();
        chk("R9 idle after drain", int_n, 0);
        ack(); fetch(8'h12);
        chk("R7 empty count", cmd_count, 0);
        mwrite();
        chk("R9 fill oe", c_oe, 1);
        chk("R9 fill byte", c_dout, 8'h00);
    endtask

    task automatic t_notify();
        push(8'hC3);
        notify = 1; tick();
        chk("R11 int_n", int_n, 0);
        ack();
        chk("R11 vector", c_dout, 8'hE7);
        fetch(8'h12);
        chk("R11 no cmd_valid", cmd_valid, 0);
        mwrite();
        chk("R11 result", c_dout, 8'hC3);
        tick();
        chk("R9 idle", int_n, 1);
    endtask

    task automatic t_fifo_full();
        for (int i = 1; i <= 5; i++) push(8'(i));
        chk("R13 full", rsp_full, 1);
        notify = 1; tick(); ack();
        for (int i = 1; i <= 4; i++) begin
            fetch(8'h12); mwrite();
            chk("R13 order", c_dout, 8'(i));
        end
        notify = 1; tick();
        chk("R9 idle after fourth", int_n, 0);
        ack(); fetch(8'h12); mwrite();
        chk("R13 fifth dropped", c_dout, 8'h00);
    endtask

    task automatic t_cmd_overflow();
        logic [63:0] exp;
        halt_pulse(); ack();
        for (int i = 0; i < 10; i++) begin
            fetch(8'h7E); mread(8'h40 + 8'(i));
        end
        fetch(8'h12);
        chk("R12 count", cmd_count, 8);
        for (int i = 0; i < 8; i++) exp[i*8 +: 8] = 8'h40 + 8'(i);
        chk("R12 bytes", cmd_bytes, exp);
        mwrite();
        chk("R12 close", c_dout, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_busy();
        t_packet();
        t_notify();
        t_fifo_full();
        t_cmd_overflow();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule